// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit unsigned operands and a carry-in. It produces a 16-bit sum and a carry-out in the same cycle, with no clock, register or state. The operand bits are split into four 4-bit groups. Each group derives a generate term and a propagate term for every bit. It computes the carries into its own bits as flat sum-of-products expressions of its carry-in, so no carry passes from bit to bit. It also exports one group generate and one group propagate.

A second-level lookahead unit takes the four group generate/propagate pairs and the external carry-in. It produces the carry into groups 1 to 3 and the final carry-out. Each of these is a flat expression that does not chain through any earlier group carry. The same lookahead structure serves at both levels. Total width and group width are parameters, so a narrower copy can be built and checked exhaustively.

Top module: `cla_adder16`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + carry_i`, taken as unsigned numbers.
- R2: `carry_o` equals bit WIDTH (the overflow bit) of `a_i + b_i + carry_i`.
- R3: For every bit, generate is `a & b` and propagate is `a | b`. A bit with both operands 1 adds a carry into the next bit whatever its incoming carry. A bit with exactly one operand 1 passes its incoming carry on.
- R4: A group whose bits all propagate passes its carry-in to the next group. A group whose combined generate is 1 sends a carry to the next group even when its carry-in is 0.
- R5: The carry into each group, and the final carry-out, equal `G | (P & c)` applied to the preceding group and its carry. The unit still computes each of them as a flat expression of the group terms and `carry_i`.
- R6: Inside a group, the carry into bit j+1 equals `g_j | (p_j & c_j)`, computed flat from the group carry-in.
- R7: All-ones operands with `carry_i` = 1 give `sum_o` all ones and `carry_o` = 1. All-ones plus zero with `carry_i` = 1 gives `sum_o` = 0 and `carry_o` = 1.
- R8: The outputs depend only on the present inputs. A change of input shows at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| carry_o | output | 1 | Carry out of the top bit |

## Verification
Two functions can meet in one evaluation: a group generating its own carry, and a carry arriving from below that the same group must also propagate. In that case each term alone already sets the carry into the next group. The bench provokes this with operands where a low group generates while higher groups fully propagate, with and without the external carry-in. It also runs every operand pair of a narrow six-bit, three-group copy, where every such overlap occurs. Each result is judged against a behavioural integer sum of the operands and the carry-in.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // per-bit carry terms
  typedef struct packed {
    logic gen;
    logic prop;
  } gp_t;

  function automatic gp_t bit_gp(input logic a, input logic b);
    gp_t r;
    r.gen  = a & b;
    r.prop = a | b;
    return r;
  endfunction

endpackage

// File: rtl/cla_lookahead.sv
// Flat lookahead: every carry is a sum of products of gen/prop and cin.
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N:0]   carry_o
);

  always_comb begin
    carry_o[0] = cin_i;
    for (int k = 1; k <= N; k++) begin
      logic acc;
      logic run;
      // cin term: AND of all propagates below k
      run = cin_i;
      for (int m = 0; m < k; m++) run = run & prop_i[m];
      acc = run;
      // generate terms: g_j AND propagates j+1..k-1
      for (int j = 0; j < k; j++) begin
        logic term;
        term = gen_i[j];
        for (int m = j + 1; m < k; m++) term = term & prop_i[m];
        acc = acc | term;
      end
      carry_o[k] = acc;
    end
  end

  // flat result must agree with chained recurrence (R5 at top, R6 in groups)
  always_comb begin
    for (int k = 0; k < N; k++) begin
      p_chain_match_r5: assert (carry_o[k+1] == (gen_i[k] | (prop_i[k] & carry_o[k])))
        else $error("lookahead carry %0d disagrees with recurrence", k + 1);
    end
  end

endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  input  logic          cin_i,
  output logic [GW-1:0] sum_o,
  output logic          grp_gen_o,
  output logic          grp_prop_o
);

  logic [GW-1:0] gen, prop;
  logic [GW:0]   carry;

  for (genvar i = 0; i < GW; i++) begin : g_bit
    gp_t gp;
    assign gp      = bit_gp(a_i[i], b_i[i]);
    assign gen[i]  = gp.gen;
    assign prop[i] = gp.prop;
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ carry[i];
  end

  // internal carries, R6
  cla_lookahead #(.N(GW)) u_bit_la (
    .gen_i   (gen),
    .prop_i  (prop),
    .cin_i   (cin_i),
    .carry_o (carry)
  );

  assign grp_prop_o = &prop;

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int j = 0; j < GW; j++) begin
      logic term;
      term = gen[j];
      for (int m = j + 1; m < GW; m++) term = term & prop[m];
      acc = acc | term;
    end
    grp_gen_o = acc;
  end

  always_comb begin
    p_bit_gp_r3: assert ((gen & ~prop) == '0)
      else $error("generate without propagate");
    p_group_out_r4: assert ((grp_gen_o | (grp_prop_o & cin_i)) == carry[GW])
      else $error("group G/P disagree with top internal carry");
    p_group_r6: assert (carry[0] == cin_i)
      else $error("group carry-in not at bit 0");
  end

endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
  parameter int WIDTH   = 16,
  parameter int GROUP_W = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);

  localparam int NG = WIDTH / GROUP_W;

  logic [NG-1:0] grp_gen, grp_prop;
  logic [NG:0]   grp_carry;

  for (genvar k = 0; k < NG; k++) begin : g_grp
    cla_group #(.GW(GROUP_W)) u_grp (
      .a_i        (a_i[k*GROUP_W +: GROUP_W]),
      .b_i        (b_i[k*GROUP_W +: GROUP_W]),
      .cin_i      (grp_carry[k]),
      .sum_o      (sum_o[k*GROUP_W +: GROUP_W]),
      .grp_gen_o  (grp_gen[k]),
      .grp_prop_o (grp_prop[k])
    );
  end

  // second level, R5
  cla_lookahead #(.N(NG)) u_grp_la (
    .gen_i   (grp_gen),
    .prop_i  (grp_prop),
    .cin_i   (carry_i),
    .carry_o (grp_carry)
  );

  assign carry_o = grp_carry[NG];

  always_comb begin
    logic [WIDTH:0] ref_sum;
    ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i};
    p_sum_r1: assert (sum_o == ref_sum[WIDTH-1:0])
      else $error("sum mismatch");
    p_cout_r2: assert (carry_o == ref_sum[WIDTH])
      else $error("carry-out mismatch");
    p_ones_r7: assert (!((&a_i) && (&b_i) && carry_i) || ((&sum_o) && carry_o))
      else $error("all-ones case wrong");
  end

endmodule

// File: tb/cla_adder16_tb.sv
module cla_adder16_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int SW = 6;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0]  a, b, s;
  logic          ci, co;
  logic [SW-1:0] sa, sb, ss;
  logic          sci, sco;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  cla_adder16 #(.WIDTH(W), .GROUP_W(4)) u_dut (
    .a_i(a), .b_i(b), .carry_i(ci), .sum_o(s), .carry_o(co)
  );

  cla_adder16 #(.WIDTH(SW), .GROUP_W(2)) u_dut_small (
    .a_i(sa), .b_i(sb), .carry_i(sci), .sum_o(ss), .carry_o(sco)
  );

  task automatic check(input string req, input longint got, input longint exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  // behavioural model: plain integer sum
  task automatic apply(input string req, input int av, input int bv, input int cv);
    longint t;
    @(posedge clk);
    a = W'(av); b = W'(bv); ci = cv[0];
    @(negedge clk);
    t = longint'(a) + longint'(b) + longint'(ci);
    check({req, " sum"}, longint'(s), t & 64'hFFFF);
    check({req, " cout"}, longint'(co), (t >> 16) & 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    a = '0; b = '0; ci = 1'b0;
    sa = '0; sb = '0; sci = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle state, R1 R2
    check("R1 idle sum", longint'(s), 0);
    check("R2 idle cout", longint'(co), 0);

    // R3: bit generate / propagate
    apply("R3 gen", 'h0001, 'h0001, 0);
    apply("R3 prop", 'h0001, 'h0000, 1);
    apply("R3 kill", 'h0000, 'h0000, 1);
    // R6: in-group carry runs
    apply("R6 g0p1", 'h0003, 'h0001, 0);
    apply("R6 cin thru", 'h0007, 'h0000, 1);
    // R4: group propagate and generate
    apply("R4 grp prop", 'h000F, 'h0000, 1);
    apply("R4 grp gen", 'h0008, 'h0008, 0);
    apply("R4 gen+prop", 'h0F88, 'h0008, 1);
    // R5: second level chains
    apply("R5 long run", 'hFFF8, 'h0008, 0);
    apply("R5 mid gen", 'h0F00, 'h0100, 0);
    apply("R5 top group", 'hF000, 'h1000, 1);
    // R7 corners
    apply("R7 ones ones", 'hFFFF, 'hFFFF, 1);
    check("R7 ones sum", longint'(s), 'hFFFF);
    check("R7 ones cout", longint'(co), 1);
    apply("R7 ones zero", 'hFFFF, 'h0000, 1);
    check("R7 wrap sum", longint'(s), 0);
    check("R7 wrap cout", longint'(co), 1);

    // R8: change without a clock edge
    @(negedge clk);
    a = 16'h1234; b = 16'h4321; ci = 1'b0;
    #1;
    check("R8 no clock sum", longint'(s), 'h5555);
    a = 16'h8000; b = 16'h8000; ci = 1'b1;
    #1;
    check("R8 no clock cout", longint'(co), 1);
    check("R8 no clock sum2", longint'(s), 1);

    // R1 R2 random full width
    for (int i = 0; i < 3000; i++) begin
      apply("R1 R2 random", $urandom_range(0, 65535), $urandom_range(0, 65535),
            $urandom_range(0, 1));
    end

    // R1 R2 exhaustive on narrow copy
    for (int x = 0; x < (1 << SW); x++) begin
      for (int y = 0; y < (1 << SW); y++) begin
        for (int c = 0; c < 2; c++) begin
          int t;
          @(posedge clk);
          sa = SW'(x); sb = SW'(y); sci = c[0];
          @(negedge clk);
          t = x + y + c;
          check("R1 narrow sum", longint'(ss), t & ((1 << SW) - 1));
          check("R2 narrow cout", longint'(sco), (t >> SW) & 1);
        end
      end
    end

    finish_run();
  end

endmodule